// File: doc/BRIEF.md
# Banked data memory address unit

This block converts data-memory references, as an instruction pipeline presents them, into physical accesses on a 4096-byte byte-wide static RAM that is divided into sixteen 256-byte banks. It holds a 4-bit bank selector, which a bank-load strobe writes and a read-back port returns. Each request carries an 8-bit file offset, an access-override bit and a full-address mode flag with a 12-bit address. From these the block forms the physical address, performs a synchronous write or read, and returns read data one cycle later.

Banks can be left out of the build with a mask parameter, and bank 15 must always be kept. A missing bank reads as zero and discards writes, so a core can run on any subset without special handling. When the override bit is clear, the low half of bank 0 and the high half of bank 15 form one contiguous 256-byte window. This makes common variables and the upper control area reachable whatever the selector holds.

Requests use a valid/ready handshake. `req_ready` is always high, so a request is accepted in every cycle that `req_valid` is high. The response side has no back-pressure: `rsp_valid` pulses for exactly one cycle per accepted read, and the consumer must take the data in that cycle.

Top module: `bdm_unit`

## Requirements
- R1: After reset, `bsr_rd` reads 0x00 and `rsp_valid` is low.
- R2: A cycle with `bsr_load` high stores `bsr_load_val[3:0]` into the bank selector. From the next cycle, `bsr_rd` reads `{4'b0000, bsr_load_val[3:0]}`: bits [7:4] always read zero, and writes to them have no effect.
- R3: With `req_full`=0 and `req_abit`=1, the physical address is `{selector[3:0], req_offset}`.
- R4: With `req_full`=0 and `req_abit`=0, offsets 0x00–0x7F address physical 0x000–0x07F, whatever the selector holds.
- R5: With `req_full`=0 and `req_abit`=0, offsets 0x80–0xFF address physical 0xF80–0xFFF.
- R6: With `req_full`=1, the physical address is `req_faddr`, and both the selector and `req_abit` are ignored.
- R7: An access whose physical bank (address bits [11:8]) is clear in `BANK_MASK` reads 0x00. A write to such a bank changes no stored byte.
- R8: An accepted read (`req_valid`=1, `req_write`=0) raises `rsp_valid` for one cycle on the following cycle, with `rsp_rdata` holding the byte at the formed address. An accepted write stores `req_wdata` at the rising edge and produces no response.
- R9: If a bank load and a banked access happen in the same cycle, the access uses the selector value held before the load.
- R10: `req_ready` is high in every cycle outside reset, so no request is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bsr_load | input | 1 | Load strobe for the bank selector |
| bsr_load_val | input | 8 | Value to load; only bits [3:0] are kept |
| bsr_rd | output | 8 | Read-back of the selector, upper nibble zero |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted; always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | Use `req_faddr` directly |
| req_abit | input | 1 | 1 = banked with selector, 0 = split access window |
| req_offset | input | 8 | File offset within a bank or window |
| req_faddr | input | 12 | Full physical address for full-address mode |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle per accepted read |
| rsp_rdata | output | 8 | Read data, meaningful while `rsp_valid` is high |

## Verification
The block has one register stage on every result. Read data and `rsp_valid` are due in the cycle after the accepting edge, and a new selector value shows on `bsr_rd` in the cycle after the load edge. The bench drives each request on a falling edge and samples on the next falling edge. That places exactly one rising edge between stimulus and check, and it also checks that a write raises no response in that slot. The same-cycle load-and-access case is checked in the same slot, so a selector value that is forwarded too early shows up as the wrong byte.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int OFF_W   = 8;
  localparam int BANK_W  = 4;
  localparam int ADDR_W  = BANK_W + OFF_W;
  localparam int DATA_W  = 8;
  localparam int NBANKS  = 1 << BANK_W;
  localparam int BANK_SZ = 1 << OFF_W;

  typedef logic [ADDR_W-1:0] paddr_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/bdm_bank_reg.sv
module bdm_bank_reg
  import bdm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_val,
  output bank_t sel,
  output byte_t rd
);
  bank_t sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= load_val[BANK_W-1:0];
  end

  assign sel = sel_q;
  assign rd  = {{(DATA_W-BANK_W){1'b0}}, sel_q};
endmodule

// File: rtl/bdm_addr_gen.sv
module bdm_addr_gen
  import bdm_pkg::*;
(
  input  bank_t  sel,
  input  logic   full,
  input  logic   abit,
  input  off_t   offset,
  input  paddr_t faddr,
  output paddr_t paddr
);
  always_comb begin
    if (full)
      paddr = faddr;
    else if (abit)
      paddr = {sel, offset};
    else
      paddr = {{BANK_W{offset[OFF_W-1]}}, offset};
  end
endmodule

// File: rtl/bdm_ram_bank.sv
module bdm_ram_bank
  import bdm_pkg::*;
(
  input  logic  clk,
  input  logic  we,
  input  logic  re,
  input  off_t  addr,
  input  byte_t wdata,
  output byte_t rdata
);
  byte_t mem [BANK_SZ];
  byte_t rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/bdm_unit.sv
module bdm_unit
  import bdm_pkg::*;
#(
  parameter logic [15:0] BANK_MASK = 16'h8003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bsr_load,
  input  logic [7:0]  bsr_load_val,
  output logic [7:0]  bsr_rd,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_full,
  input  logic        req_abit,
  input  logic [7:0]  req_offset,
  input  logic [11:0] req_faddr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata
);
  bank_t  sel;
  paddr_t phys_addr;
  bank_t  acc_bank;
  logic   wr_en, rd_en;
  bank_t  rsp_bank_q;
  logic   rsp_valid_q;
  byte_t  bank_rd [NBANKS];

  bdm_bank_reg u_bank_reg (
    .clk(clk), .rst_n(rst_n), .load(bsr_load), .load_val(bsr_load_val),
    .sel(sel), .rd(bsr_rd)
  );

  bdm_addr_gen u_addr_gen (
    .sel(sel), .full(req_full), .abit(req_abit), .offset(req_offset),
    .faddr(req_faddr), .paddr(phys_addr)
  );

  assign req_ready = rst_n;
  assign acc_bank  = phys_addr[ADDR_W-1:OFF_W];
  assign wr_en     = req_valid && req_ready && req_write;
  assign rd_en     = req_valid && req_ready && !req_write;

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    if (BANK_MASK[b]) begin : g_impl
      logic hit;
      assign hit = (acc_bank == BANK_W'(b));
      bdm_ram_bank u_ram (
        .clk(clk), .we(wr_en && hit), .re(rd_en && hit),
        .addr(phys_addr[OFF_W-1:0]), .wdata(req_wdata), .rdata(bank_rd[b])
      );
    end else begin : g_absent
      assign bank_rd[b] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_bank_q  <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) rsp_bank_q <= acc_bank;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = bank_rd[rsp_bank_q];
endmodule

// File: rtl/bdm_unit_chk.sv
module bdm_unit_chk #(
  parameter logic [15:0] BANK_MASK = 16'h8003
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bsr_load,
  input logic [7:0]  bsr_load_val,
  input logic [7:0]  bsr_rd,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_full,
  input logic        req_abit,
  input logic [7:0]  req_offset,
  input logic [11:0] req_faddr,
  input logic        rsp_valid,
  input logic [7:0]  rsp_rdata,
  input logic [11:0] phys_addr
);
  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_load |=> bsr_rd == {4'b0000, $past(bsr_load_val[3:0])});

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bsr_load |=> $stable(bsr_rd));

  // R3
  banked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_full && req_abit) |-> phys_addr == {bsr_rd[3:0], req_offset});

  // R4
  low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_full && !req_abit && !req_offset[7]) |-> phys_addr == {4'h0, req_offset});

  // R5
  high_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_full && !req_abit && req_offset[7]) |-> phys_addr == {4'hF, req_offset});

  // R6
  full_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_full |-> phys_addr == req_faddr);

  // R8
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid && !req_write));

  // R7
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !BANK_MASK[$past(phys_addr[11:8])]) |-> rsp_rdata == 8'h00);
endmodule

bind bdm_unit bdm_unit_chk #(.BANK_MASK(BANK_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bsr_load(bsr_load), .bsr_load_val(bsr_load_val),
  .bsr_rd(bsr_rd), .req_valid(req_valid), .req_write(req_write),
  .req_full(req_full), .req_abit(req_abit), .req_offset(req_offset),
  .req_faddr(req_faddr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .phys_addr(phys_addr)
);

// File: tb/bdm_unit_test.sv
module bdm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bsr_load = 1'b0;
  logic [7:0]  bsr_load_val = '0;
  logic [7:0]  bsr_rd;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_full = 1'b0;
  logic        req_abit = 1'b0;
  logic [7:0]  req_offset = '0;
  logic [11:0] req_faddr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bdm_unit uut (
    .clk(clk), .rst_n(rst_n), .bsr_load(bsr_load), .bsr_load_val(bsr_load_val),
    .bsr_rd(bsr_rd), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_full(req_full), .req_abit(req_abit),
    .req_offset(req_offset), .req_faddr(req_faddr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // kind: 0 = bank load, 1 = write, 2 = read
  typedef struct packed {
    logic [1:0]  kind;
    logic        full;
    logic        abit;
    logic [7:0]  off;
    logic [11:0] fa;
    logic [7:0]  dat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 8'h00, 12'h000, 8'h01}, // R2 select bank 1
    '{2'd1, 1'b0, 1'b1, 8'h20, 12'h000, 8'hA1}, // R3 -> 0x120
    '{2'd1, 1'b0, 1'b0, 8'h20, 12'h000, 8'h5B}, // R4 -> 0x020
    '{2'd1, 1'b0, 1'b0, 8'h90, 12'h000, 8'hC3}, // R5 -> 0xF90
    '{2'd2, 1'b1, 1'b0, 8'h00, 12'h120, 8'hA1}, // R6
    '{2'd2, 1'b1, 1'b0, 8'h00, 12'h020, 8'h5B}, // R6
    '{2'd2, 1'b1, 1'b0, 8'h00, 12'hF90, 8'hC3}, // R6
    '{2'd2, 1'b0, 1'b1, 8'h20, 12'h000, 8'hA1}, // R3
    '{2'd0, 1'b0, 1'b0, 8'h00, 12'h000, 8'hF0}, // R2 upper bits dropped
    '{2'd2, 1'b0, 1'b1, 8'h20, 12'h000, 8'h5B}, // R3 bank 0
    '{2'd0, 1'b0, 1'b0, 8'h00, 12'h000, 8'h0F}, // R2 bank 15
    '{2'd2, 1'b0, 1'b1, 8'h90, 12'h000, 8'hC3}, // R3 0xF90
    '{2'd2, 1'b0, 1'b0, 8'h20, 12'h000, 8'h5B}, // R4 selector ignored
    '{2'd1, 1'b1, 1'b0, 8'h00, 12'h220, 8'hEE}, // R7 absent bank write
    '{2'd2, 1'b1, 1'b0, 8'h00, 12'h220, 8'h00}, // R7 absent bank reads 0
    '{2'd2, 1'b1, 1'b0, 8'h00, 12'h120, 8'hA1}, // R7 stored bytes intact
    '{2'd2, 1'b1, 1'b1, 8'h90, 12'h020, 8'h5B}  // R6 abit and offset ignored
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.kind == 2'd0)               return "R2";
    if (v.full && v.fa[11:8] == 4'h2) return "R7";
    if (v.full)                       return "R6";
    if (v.abit)                       return "R3";
    if (v.off[7])                     return "R5";
    return "R4";
  endfunction

  // drive at a falling edge, check at the next falling edge
  task automatic do_op(input bit ld, input logic [7:0] ldv, input bit acc,
                       input bit wr, input bit full, input bit abit,
                       input logic [7:0] off, input logic [11:0] fa,
                       input logic [7:0] wd, input logic [7:0] exp,
                       input string tag);
    bsr_load = ld; bsr_load_val = ldv;
    req_valid = acc; req_write = wr; req_full = full; req_abit = abit;
    req_offset = off; req_faddr = fa; req_wdata = wd;
    @(negedge clk);
    bsr_load = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    if (ld)
      check(bsr_rd == {4'h0, ldv[3:0]}, tag, "bsr_rd", bsr_rd, {4'h0, ldv[3:0]});
    if (acc && !wr) begin
      check(rsp_valid == 1'b1, tag, "rsp_valid", rsp_valid, 1);
      check(rsp_rdata == exp, tag, "rsp_rdata", rsp_rdata, exp);
    end else begin
      check(rsp_valid == 1'b0, "R8", "rsp_valid idle", rsp_valid, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bsr_rd == 8'h00, "R1", "bsr_rd in reset", bsr_rd, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bsr_rd == 8'h00, "R1", "bsr_rd after reset", bsr_rd, 0);
    check(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      do_op(v.kind == 2'd0, v.dat, v.kind != 2'd0, v.kind == 2'd1, v.full,
            v.abit, v.off, v.fa, v.dat, v.dat, tag_of(v));
    end

    // R10 ready stays high while requests are back to back
    check(req_ready == 1'b1, "R10", "req_ready busy", req_ready, 1);

    // R9 same-cycle load and banked read: selector is 0x0F now
    do_op(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 12'hF20, 8'h77, 8'h00, "R9");
    do_op(1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 12'h000, 8'h00, 8'h77, "R9");
    do_op(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 12'h000, 8'h00, 8'hA1, "R9");

    // R5 top of the window reaches 0xFFF
    do_op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 12'h000, 8'h3C, 8'h00, "R5");
    do_op(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 12'hFFF, 8'h00, 8'h3C, "R5");
    // R4 top of the low half reaches 0x07F
    do_op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'h7F, 12'h000, 8'h96, 8'h00, "R4");
    do_op(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 12'h07F, 8'h00, 8'h96, "R4");

    // R7 banked write into absent bank 5 leaves bank 0 alias untouched
    do_op(1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 12'h000, 8'h00, 8'h00, "R7");
    do_op(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h20, 12'h000, 8'hDD, 8'h00, "R7");
    do_op(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h20, 12'h000, 8'h00, 8'h00, "R7");
    do_op(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h20, 12'h000, 8'h00, 8'h5B, "R7");

    // R8 one response per read, none in the following idle cycle
    @(negedge clk);
    check(rsp_valid == 1'b0, "R8", "rsp_valid after idle", rsp_valid, 0);

    // R1 reset mid-run clears the selector
    rst_n = 1'b0;
    @(negedge clk);
    check(bsr_rd == 8'h00, "R1", "bsr_rd after second reset", bsr_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule